// File: doc/BRIEF.md
# PLL Bring-Up and Main-Clock Handover Sequencer

This controller starts a phase-locked loop and then moves the chip's main clock onto it without risking a hang or a flash timing violation. A single start request is all it needs. The sequencer then runs these steps in order:

1. It points the loop's input at the internal high-speed oscillator.
2. It turns the loop on.
3. It holds the loop's reset for a programmed number of reference cycles.
4. It waits for lock, with an optional settle interval after lock.
5. It opens the loop output.
6. It writes the requested flash wait-state count.
7. Only then does it change the main-clock select code.

If lock never arrives, the sequencer stops in an error state and leaves the clock select untouched. It does the same if any candidate clock source is reported dead at the moment of the switch. The analog loop, the glitch-free clock mux and the divider arithmetic all sit outside this block.

All intervals are parameters counted in reference-clock cycles:

- `EN_CYC` is the enable-to-reset-release time, about 1 µs.
- `SETTLE_CYC` is the post-lock settle time, about 100 µs.
- `LOCK_TO_CYC` is the lock timeout.

A new start is taken only when the sequencer is idle, finished or in error. When a new start is taken, the main-clock select first drops back to the boot source, so the loop is never reset while the system runs from it.

Top module: `pll_switch_seq`

## Requirements
- R1: After reset: `pll_en_o`, `pll_rstb_o`, `pll_out_en_o`, `busy_o`, `done_o` and `err_o` are 0; `pll_insel_o` is 1; `flash_ws_o` is 0; `mclk_sel_o` is 2'b00 (boot source).
- R2: `start_i` is accepted only while the sequencer is idle, done or in error. A start given while `busy_o` is high has no effect on any output.
- R3: When a start is accepted, `pll_insel_o` goes to 0 (internal high-speed oscillator) and `mclk_sel_o` goes to 2'b00 at the next edge. `pll_en_o` rises one cycle after that.
- R4: `pll_rstb_o` rises exactly `EN_CYC` cycles after `pll_en_o` rises.
- R5: The first cycle with `pll_lock_i` high after reset release ends the lock wait. With `settle_en_i` = 1, `pll_out_en_o` rises `SETTLE_CYC`+1 cycles after that cycle. With `settle_en_i` = 0, it rises 1 cycle after it. `mclk_sel_o` never becomes 2'b10 unless lock was seen.
- R6: `flash_ws_o` takes the value of `flash_ws_i` one cycle after `pll_out_en_o` rises. This is one cycle before `mclk_sel_o` changes.
- R7: If every bit of `src_alive_i` is 1 in the switch cycle, `mclk_sel_o` becomes 2'b10 and `done_o` is high for exactly one cycle.
- R8: If any bit of `src_alive_i` is 0 in the switch cycle, the sequencer enters error: `err_o` = 1, `mclk_sel_o` is unchanged, and `pll_en_o`, `pll_rstb_o` and `pll_out_en_o` are 0.
- R9: If `pll_lock_i` stays low for `LOCK_TO_CYC` cycles after reset release, the sequencer enters error with `mclk_sel_o` unchanged.
- R10: `busy_o` is 1 from the cycle after an accepted start until the sequencer reaches done or error. It is 0 whenever `err_o` or `done_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to run the bring-up sequence |
| settle_en_i | input | 1 | Enable the post-lock settle interval |
| pll_lock_i | input | 1 | Lock indication from the loop |
| flash_ws_i | input | WS_W | Wait-state count to program before the switch |
| src_alive_i | input | NSRC | One bit per candidate clock source, 1 = running |
| pll_insel_o | output | 1 | Loop input select, 0 = internal high-speed oscillator |
| pll_en_o | output | 1 | Loop enable |
| pll_rstb_o | output | 1 | Loop reset release, active low reset |
| pll_out_en_o | output | 1 | Loop output enable (bypass released) |
| flash_ws_o | output | WS_W | Programmed flash wait states |
| mclk_sel_o | output | 2 | Main-clock select, 2'b10 = loop output |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse when the switch completes |
| err_o | output | 1 | Sequence aborted (timeout or dead source) |

## Verification
The bound checker watches the ordering rules on every cycle:

- the reset release never arrives fewer than `EN_CYC` cycles after enable;
- the select never moves to the loop without a lock having been seen;
- the wait states are never written in the same cycle as the select change;
- entry into error never moves the select;
- done is a single-cycle pulse outside busy.

The bench's scenarios cover the rest:

- exact cycle counts for the settle and timeout windows;
- the dead-source refusal;
- a restart from done that returns the select to the boot source;
- a start ignored while busy.

A behavioural model in the bench predicts every output on every cycle.

// File: rtl/pss_pkg.sv
package pss_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_ENABLE, S_RST_WAIT, S_LOCK_WAIT, S_SETTLE,
    S_FLASH_WS, S_SWITCH, S_DONE, S_ERROR
  } pss_state_e;
  localparam logic [1:0] MSEL_BOOT = 2'b00;
  localparam logic [1:0] MSEL_PLL  = 2'b10;
endpackage

// File: rtl/pss_timer.sv
module pss_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = load_i || (cnt_q != '0);

  always_comb begin
    if (load_i) cnt_d = load_val_i;
    else        cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/pss_fsm.sv
module pss_fsm
  import pss_pkg::*;
#(
  parameter int EN_CYC      = 100,
  parameter int SETTLE_CYC  = 10000,
  parameter int LOCK_TO_CYC = 50000,
  parameter int NSRC        = 4,
  parameter int CNT_W       = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             settle_en_i,
  input  logic             lock_i,
  input  logic [NSRC-1:0]  src_alive_i,
  input  logic             zero_i,
  output logic             load_o,
  output logic [CNT_W-1:0] load_val_o,
  output logic             accept_o,
  output logic             ws_wr_o,
  output logic             switch_go_o,
  output pss_state_e       state_o
);
  pss_state_e st_q, st_d;
  logic       all_alive;

  assign all_alive   = &src_alive_i;
  assign accept_o    = start_i && (st_q == S_IDLE || st_q == S_DONE || st_q == S_ERROR);
  assign ws_wr_o     = (st_q == S_FLASH_WS);
  assign switch_go_o = (st_q == S_SWITCH) && all_alive;
  assign state_o     = st_q;

  always_comb begin
    st_d       = st_q;
    load_o     = 1'b0;
    load_val_o = '0;
    unique case (st_q)
      S_IDLE, S_DONE, S_ERROR: if (start_i) st_d = S_ENABLE;
      S_ENABLE: begin
        st_d       = S_RST_WAIT;
        load_o     = 1'b1;
        load_val_o = CNT_W'(EN_CYC - 1);
      end
      S_RST_WAIT: if (zero_i) begin
        st_d       = S_LOCK_WAIT;
        load_o     = 1'b1;
        load_val_o = CNT_W'(LOCK_TO_CYC - 1);
      end
      S_LOCK_WAIT: begin
        if (lock_i) begin
          if (settle_en_i) begin
            st_d       = S_SETTLE;
            load_o     = 1'b1;
            load_val_o = CNT_W'(SETTLE_CYC - 1);
          end else begin
            st_d = S_FLASH_WS;
          end
        end else if (zero_i) begin
          st_d = S_ERROR;
        end
      end
      S_SETTLE:   if (zero_i) st_d = S_FLASH_WS;
      S_FLASH_WS: st_d = S_SWITCH;
      S_SWITCH:   st_d = all_alive ? S_DONE : S_ERROR;
      default:    st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= S_IDLE;
    else        st_q <= st_d;
  end
endmodule

// File: rtl/pss_outreg.sv
module pss_outreg
  import pss_pkg::*;
#(
  parameter int WS_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            accept_i,
  input  logic            ws_wr_i,
  input  logic            switch_go_i,
  input  logic [WS_W-1:0] flash_ws_i,
  output logic            insel_o,
  output logic [WS_W-1:0] flash_ws_o,
  output logic [1:0]      mclk_sel_o,
  output logic            done_o
);
  logic       sel_en;
  logic [1:0] sel_d;

  assign sel_en = accept_i || switch_go_i;
  assign sel_d  = switch_go_i ? MSEL_PLL : MSEL_BOOT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      insel_o    <= 1'b1;
      flash_ws_o <= '0;
      mclk_sel_o <= MSEL_BOOT;
      done_o     <= 1'b0;
    end else begin
      done_o <= switch_go_i;
      if (accept_i) insel_o    <= 1'b0;
      if (ws_wr_i)  flash_ws_o <= flash_ws_i;
      if (sel_en)   mclk_sel_o <= sel_d;
    end
  end
endmodule

// File: rtl/pll_switch_seq.sv
module pll_switch_seq
  import pss_pkg::*;
#(
  parameter int EN_CYC      = 100,
  parameter int SETTLE_CYC  = 10000,
  parameter int LOCK_TO_CYC = 50000,
  parameter int WS_W        = 4,
  parameter int NSRC        = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            settle_en_i,
  input  logic            pll_lock_i,
  input  logic [WS_W-1:0] flash_ws_i,
  input  logic [NSRC-1:0] src_alive_i,
  output logic            pll_insel_o,
  output logic            pll_en_o,
  output logic            pll_rstb_o,
  output logic            pll_out_en_o,
  output logic [WS_W-1:0] flash_ws_o,
  output logic [1:0]      mclk_sel_o,
  output logic            busy_o,
  output logic            done_o,
  output logic            err_o
);
  localparam int MAX_A = (EN_CYC > SETTLE_CYC) ? EN_CYC : SETTLE_CYC;
  localparam int MAX_C = (MAX_A > LOCK_TO_CYC) ? MAX_A : LOCK_TO_CYC;
  localparam int CNT_W = $clog2(MAX_C + 1);

  pss_state_e       st;
  logic             zero, load, accept, ws_wr, switch_go;
  logic [CNT_W-1:0] load_val;

  pss_fsm #(
    .EN_CYC(EN_CYC), .SETTLE_CYC(SETTLE_CYC), .LOCK_TO_CYC(LOCK_TO_CYC),
    .NSRC(NSRC), .CNT_W(CNT_W)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .settle_en_i(settle_en_i),
    .lock_i(pll_lock_i), .src_alive_i(src_alive_i), .zero_i(zero),
    .load_o(load), .load_val_o(load_val), .accept_o(accept), .ws_wr_o(ws_wr),
    .switch_go_o(switch_go), .state_o(st)
  );

  pss_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load_i(load), .load_val_i(load_val), .zero_o(zero)
  );

  pss_outreg #(.WS_W(WS_W)) u_out (
    .clk(clk), .rst_n(rst_n), .accept_i(accept), .ws_wr_i(ws_wr),
    .switch_go_i(switch_go), .flash_ws_i(flash_ws_i), .insel_o(pll_insel_o),
    .flash_ws_o(flash_ws_o), .mclk_sel_o(mclk_sel_o), .done_o(done_o)
  );

  always_comb begin
    pll_en_o     = 1'b0;
    pll_rstb_o   = 1'b0;
    pll_out_en_o = 1'b0;
    busy_o       = 1'b0;
    err_o        = 1'b0;
    unique case (st)
      S_IDLE:      ;
      S_ENABLE:    busy_o = 1'b1;
      S_RST_WAIT:  begin busy_o = 1'b1; pll_en_o = 1'b1; end
      S_LOCK_WAIT,
      S_SETTLE:    begin busy_o = 1'b1; pll_en_o = 1'b1; pll_rstb_o = 1'b1; end
      S_FLASH_WS,
      S_SWITCH:    begin busy_o = 1'b1; pll_en_o = 1'b1; pll_rstb_o = 1'b1; pll_out_en_o = 1'b1; end
      S_DONE:      begin pll_en_o = 1'b1; pll_rstb_o = 1'b1; pll_out_en_o = 1'b1; end
      S_ERROR:     err_o = 1'b1;
      default:     ;
    endcase
  end
endmodule

// File: rtl/pss_checker.sv
module pss_checker #(
  parameter int EN_CYC = 100,
  parameter int WS_W   = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            pll_lock_i,
  input logic            pll_insel_o,
  input logic            pll_en_o,
  input logic            pll_rstb_o,
  input logic            pll_out_en_o,
  input logic [WS_W-1:0] flash_ws_o,
  input logic [1:0]      mclk_sel_o,
  input logic            busy_o,
  input logic            done_o,
  input logic            err_o
);
  int   en_cnt;
  logic lock_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_cnt    <= 0;
      lock_seen <= 1'b0;
    end else begin
      if (!pll_en_o)           en_cnt <= 0;
      else if (en_cnt < EN_CYC) en_cnt <= en_cnt + 1;
      if (!pll_en_o)                    lock_seen <= 1'b0;
      else if (pll_lock_i && pll_rstb_o) lock_seen <= 1'b1;
    end
  end

  assert_insel_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pll_en_o) |-> (!pll_insel_o && !$past(pll_insel_o)));

  assert_rstb_delay_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pll_rstb_o) |-> (en_cnt >= EN_CYC));

  assert_sel_after_lock_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(mclk_sel_o) && mclk_sel_o == 2'b10) |-> lock_seen);

  assert_ws_before_sel_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(mclk_sel_o) && mclk_sel_o == 2'b10) |-> ($stable(flash_ws_o) && $past(pll_out_en_o)));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_err_keeps_sel_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> $stable(mclk_sel_o));

  assert_busy_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (!err_o && !done_o));
endmodule

bind pll_switch_seq pss_checker #(.EN_CYC(EN_CYC), .WS_W(WS_W)) u_pss_checker (
  .clk(clk), .rst_n(rst_n), .pll_lock_i(pll_lock_i), .pll_insel_o(pll_insel_o),
  .pll_en_o(pll_en_o), .pll_rstb_o(pll_rstb_o), .pll_out_en_o(pll_out_en_o),
  .flash_ws_o(flash_ws_o), .mclk_sel_o(mclk_sel_o), .busy_o(busy_o),
  .done_o(done_o), .err_o(err_o)
);

// File: tb/tb_pll_switch_seq.sv
module tb_pll_switch_seq;
  localparam int EN  = 6;
  localparam int SET = 15;
  localparam int TO  = 40;
  localparam int WSW = 4;
  localparam int NS  = 4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0, settle_en = 1'b0, lock = 1'b0;
  logic [WSW-1:0] ws_in = '0;
  logic [NS-1:0]  alive = '1;
  logic           insel, pen, prstb, poe, busy, done, err;
  logic [WSW-1:0] ws_out;
  logic [1:0]     sel;

  int checks = 0, errors = 0, cyc = 0;

  always #5 clk = ~clk;

  pll_switch_seq #(.EN_CYC(EN), .SETTLE_CYC(SET), .LOCK_TO_CYC(TO), .WS_W(WSW), .NSRC(NS)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .settle_en_i(settle_en), .pll_lock_i(lock),
    .flash_ws_i(ws_in), .src_alive_i(alive), .pll_insel_o(insel), .pll_en_o(pen),
    .pll_rstb_o(prstb), .pll_out_en_o(poe), .flash_ws_o(ws_out), .mclk_sel_o(sel),
    .busy_o(busy), .done_o(done), .err_o(err)
  );

  // behavioural reference: phase 0 idle,1 start,2 pre-release,3 lock wait,4 settle,5 ws,6 switch,7 done,8 error
  int             ph, left;
  logic           m_insel, m_done;
  logic [WSW-1:0] m_ws;
  logic [1:0]     m_sel;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph = 0; left = 0; m_insel = 1'b1; m_done = 1'b0; m_ws = '0; m_sel = 2'b00;
    end else begin
      m_done = 1'b0;
      case (ph)
        0, 7, 8: if (start) begin ph = 1; m_insel = 1'b0; m_sel = 2'b00; end
        1: begin ph = 2; left = EN; end
        2: begin left--; if (left == 0) begin ph = 3; left = TO; end end
        3: if (lock) begin
             if (settle_en) begin ph = 4; left = SET; end else ph = 5;
           end else begin left--; if (left == 0) ph = 8; end
        4: begin left--; if (left == 0) ph = 5; end
        5: begin m_ws = ws_in; ph = 6; end
        6: if (&alive) begin m_sel = 2'b10; m_done = 1'b1; ph = 7; end else ph = 8;
        default: ph = 0;
      endcase
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk("R3 pll_insel", 32'(insel), 32'(m_insel));
      chk("R4 pll_en", 32'(pen), 32'(ph >= 2 && ph <= 7));
      chk("R4 pll_rstb", 32'(prstb), 32'(ph >= 3 && ph <= 7));
      chk("R5 pll_out_en", 32'(poe), 32'(ph >= 5 && ph <= 7));
      chk("R6 flash_ws", 32'(ws_out), 32'(m_ws));
      chk("R7 mclk_sel", 32'(sel), 32'(m_sel));
      chk("R7 done", 32'(done), 32'(m_done));
      chk("R8 err", 32'(err), 32'(ph == 8));
      chk("R10 busy", 32'(busy), 32'(ph >= 1 && ph <= 6));
    end
    if (cyc > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired at cycle %0d: actual hung expected finished", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // ordering measurements at the ports
  int   en_rise = -1;
  logic pen_prev = 1'b0, prstb_prev = 1'b0, insel_prev = 1'b1;
  logic [1:0]     sel_prev = 2'b00;
  logic [WSW-1:0] ws_prev = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (pen && !pen_prev) begin
        en_rise = cyc;
        chk("R3 insel low before enable", 32'(insel_prev), 32'd0);
      end
      if (prstb && !prstb_prev) chk("R4 release gap", 32'(cyc - en_rise), 32'(EN));
      if (sel == 2'b10 && sel_prev != 2'b10)
        chk("R6 ws written before select", 32'(ws_prev), 32'(ws_out));
    end
    pen_prev = pen; prstb_prev = prstb; insel_prev = insel; sel_prev = sel; ws_prev = ws_out;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_start();
    start = 1'b1; tick(1); start = 1'b0;
  endtask

  initial begin
    tick(3);
    // R1 reset values
    chk("R1 pll_en", 32'(pen), 0);
    chk("R1 pll_rstb", 32'(prstb), 0);
    chk("R1 out_en", 32'(poe), 0);
    chk("R1 insel", 32'(insel), 1);
    chk("R1 mclk_sel", 32'(sel), 0);
    chk("R1 flags", 32'({busy, done, err}), 0);
    rst_n = 1'b1;
    tick(2);

    // run A: settle on, lock arrives late, start pulsed again while busy (R2)
    settle_en = 1'b1; ws_in = 4'd5; alive = '1;
    pulse_start();
    tick(12);
    start = 1'b1; tick(2); start = 1'b0;
    lock = 1'b1;
    tick(3);
    chk("R2 busy start ignored", 32'(busy), 1);
    tick(SET + 6);
    chk("R7 select on loop", 32'(sel), 32'h2);
    chk("R6 wait states", 32'(ws_out), 5);

    // run B: restart from done, lock never comes -> timeout (R9)
    lock = 1'b0;
    pulse_start();
    tick(1);
    chk("R3 select back to boot", 32'(sel), 0);
    tick(EN + TO + 4);
    chk("R9 timeout error", 32'(err), 1);
    chk("R9 select unchanged", 32'(sel), 0);

    // run C: from error, no settle, one source dead -> refused (R8)
    settle_en = 1'b0; lock = 1'b1; ws_in = 4'd9; alive = 4'b1011;
    pulse_start();
    tick(EN + 8);
    chk("R8 dead source error", 32'(err), 1);
    chk("R8 select unchanged", 32'(sel), 0);
    chk("R8 loop off", 32'({pen, prstb, poe}), 0);

    // run D: no settle, all alive -> done (R5 short path)
    alive = '1; ws_in = 4'd3;
    pulse_start();
    tick(EN + 8);
    chk("R5 done without settle", 32'(sel), 32'h2);
    chk("R10 not busy at end", 32'(busy), 0);

    tick(3);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule